// File: doc/BRIEF.md
# DMA Byte Handshake Termination Controller

This block sits on the host side of a low pin count bus during DMA cycles. After a transfer header has named the direction, the transfer size and the width of the channel, the peripheral answers each data byte with a 4-bit handshake code. The block reads that code to decide three things. It decides whether another byte follows. It decides whether the transfer stops early. It also decides whether the request line it presents to the legacy DMA engine stays asserted for a later transfer.

When a transfer finishes, the block issues a one-cycle completion pulse. The pulse carries the number of bytes that actually moved and a flag for an error-tagged ending. On writes, the same cycle also issues a memory write strobe with the packed data. A verify transfer moves data across the bus like a write, but the block never writes it to memory. Bus framing and DMA arbitration belong to neighbouring logic.

Top module: `lpc_dma_sync_term`

## Requirements
- R1: A header (`hdr_valid` high while idle) starts a transfer and drives `dreq_hold` high on the next cycle. A header that arrives while a transfer is still in progress is ignored.
- R2: The ready codes are 4'b0000 (end), 4'b1010 (end with error) and 4'b1001 (more data). Any other handshake code is a wait state: no byte is counted and no completion is produced. A byte strobe while idle is also ignored.
- R3: Code 0000 or 1010 ends the transfer after the current byte, and `dreq_hold` is low in the cycle of the completion pulse. This also applies when the byte is the first byte of a 16-bit transfer, so the second byte never moves.
- R4: Code 1001 on the last byte of the stated size completes the transfer, keeps `dreq_hold` high, and returns the block to idle so that it waits for the next header.
- R5: On a 16-bit transfer (`hdr_size16`=1), code 1001 on the first byte produces no completion, and the block waits for a second byte.
- R6: `xfer_done` is high for exactly one cycle per transfer. In that cycle, `xfer_bytes` gives the bytes moved (1 or 2), and `xfer_err_end` is high exactly when the ending code was 1010.
- R7: `chan_err` pulses together with `xfer_done` when an end code arrives on the first byte of a 16-bit transfer on a 16-bit channel (`hdr_chan16`=1). An early end on an 8-bit channel does not raise it.
- R8: For a write (`hdr_dir`=2'b01), `mem_we` pulses together with `xfer_done`. `mem_data` places the first byte in bits [7:0] and the second byte in bits [15:8]. After an 8-bit transfer, the upper byte is zero. After a 16-bit transfer that was cut short, the upper byte is filler from a free-running pseudo-random generator.
- R9: Reads (`hdr_dir`=2'b00) and verifies (`hdr_dir`=2'b10) never raise `mem_we`.
- R10: After reset, `dreq_hold`, `xfer_done`, `mem_we` and `chan_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_valid | input | 1 | Transfer header present |
| hdr_dir | input | 2 | 00 read, 01 write, 10 verify |
| hdr_size16 | input | 1 | Transfer size is 16 bit |
| hdr_chan16 | input | 1 | Channel is 16 bit wide |
| byte_stb | input | 1 | A data byte and its handshake code are present |
| sync_code | input | 4 | Handshake code for the byte |
| byte_data | input | DW | Data byte driven by the peripheral |
| dreq_hold | output | 1 | DMA request kept asserted upstream |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_bytes | output | 2 | Bytes moved in the completed transfer |
| xfer_err_end | output | 1 | Ending code was the error-tagged one |
| chan_err | output | 1 | Early end on the first byte of a 16-bit channel transfer |
| mem_we | output | 1 | Memory write strobe |
| mem_data | output | 2*DW | Packed write data |

## Verification
The hardest condition to reach is a transfer on a 16-bit channel that the peripheral ends on its first byte. Reaching it needs a 16-bit header followed by an end code before any "more" code, while the write direction is selected so that the padding path also runs. The bench builds this case with both end codes. It then contrasts it with the same early end on an 8-bit channel, and with a stray header injected between the two bytes of a write.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;
    typedef enum logic [1:0] {
        DIR_RD  = 2'b00,
        DIR_WR  = 2'b01,
        DIR_VFY = 2'b10
    } dir_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACT  = 1'b1
    } phase_e;

    localparam logic [3:0] CODE_END     = 4'b0000;
    localparam logic [3:0] CODE_END_ERR = 4'b1010;
    localparam logic [3:0] CODE_MORE    = 4'b1001;
endpackage

// File: rtl/dma_sync_decode.sv
module dma_sync_decode
    import dma_sync_pkg::*;
(
    input  logic [3:0] code,
    output logic       is_ready,
    output logic       is_end,
    output logic       is_err
);
    always_comb begin
        is_end   = (code == CODE_END) || (code == CODE_END_ERR);
        is_err   = (code == CODE_END_ERR);
        is_ready = is_end || (code == CODE_MORE);
    end
endmodule

// File: rtl/dma_pad_lfsr.sv
module dma_pad_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 8,
    parameter logic [15:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] pad
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[W-1:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= {{(W-1){1'b0}}, 1'b1};
        else        lfsr_q <= lfsr_d;
    end

    assign pad = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/lpc_dma_sync_term.sv
module lpc_dma_sync_term
    import dma_sync_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hdr_valid,
    input  logic [1:0]      hdr_dir,
    input  logic            hdr_size16,
    input  logic            hdr_chan16,
    input  logic            byte_stb,
    input  logic [3:0]      sync_code,
    input  logic [DW-1:0]   byte_data,
    output logic            dreq_hold,
    output logic            xfer_done,
    output logic [1:0]      xfer_bytes,
    output logic            xfer_err_end,
    output logic            chan_err,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_data
);
    localparam int WW = 2 * DW;

    typedef struct packed {
        phase_e          phase;
        logic            idx;
        dir_e            dir;
        logic            x16;
        logic            c16;
        logic [DW-1:0]   lo;
        logic            dreq;
        logic            done;
        logic [1:0]      nbytes;
        logic            derr;
        logic            cerr;
        logic            we;
        logic [WW-1:0]   wdata;
    } st_t;

    st_t st_d, st_q;

    logic          c_ready, c_end, c_err;
    logic [DW-1:0] pad;

    dma_sync_decode u_dec (
        .code     (sync_code),
        .is_ready (c_ready),
        .is_end   (c_end),
        .is_err   (c_err)
    );

    dma_pad_lfsr #(.W(16), .OUT_W(DW)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .pad   (pad)
    );

    logic fin;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        st_d.derr = 1'b0;
        st_d.cerr = 1'b0;
        fin       = c_end || st_q.idx || !st_q.x16;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (hdr_valid) begin
                    st_d.phase = PH_ACT;
                    st_d.idx   = 1'b0;
                    st_d.dir   = dir_e'(hdr_dir);
                    st_d.x16   = hdr_size16;
                    st_d.c16   = hdr_chan16;
                    st_d.lo    = '0;
                    st_d.dreq  = 1'b1;
                end
            end
            PH_ACT: begin
                if (byte_stb && c_ready) begin
                    if (!fin) begin
                        st_d.idx = 1'b1;
                        st_d.lo  = byte_data;
                    end else begin
                        st_d.phase  = PH_IDLE;
                        st_d.done   = 1'b1;
                        st_d.nbytes = st_q.idx ? 2'd2 : 2'd1;
                        st_d.derr   = c_err;
                        st_d.cerr   = c_end && !st_q.idx && st_q.x16 && st_q.c16;
                        st_d.we     = (st_q.dir == DIR_WR);
                        if (c_end) st_d.dreq = 1'b0;
                        if (st_q.idx)      st_d.wdata = {byte_data, st_q.lo};
                        else if (st_q.x16) st_d.wdata = {pad, byte_data};
                        else               st_d.wdata = {{DW{1'b0}}, byte_data};
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.dir   <= DIR_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign dreq_hold    = st_q.dreq;
    assign xfer_done    = st_q.done;
    assign xfer_bytes   = st_q.nbytes;
    assign xfer_err_end = st_q.derr;
    assign chan_err     = st_q.cerr;
    assign mem_we       = st_q.we;
    assign mem_data     = st_q.wdata;
endmodule

// File: rtl/dma_sync_chk.sv
module dma_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_stb,
    input logic [3:0] sync_code,
    input logic       dreq_hold,
    input logic       xfer_done,
    input logic [1:0] xfer_bytes,
    input logic       xfer_err_end,
    input logic       chan_err,
    input logic       mem_we
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);                                            // R6
    AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (xfer_bytes == 2'd1 || xfer_bytes == 2'd2));            // R6
    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> xfer_done);                                                // R8
    AST_CHAN_ERR_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err |-> (xfer_done && xfer_bytes == 2'd1));                      // R7
    AST_ERR_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_err_end) |-> !dreq_hold);                          // R3
    AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ($past(byte_stb) && ($past(sync_code) == 4'b0000 ||
                       $past(sync_code) == 4'b1010 || $past(sync_code) == 4'b1001))); // R2
endmodule

bind lpc_dma_sync_term dma_sync_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_stb     (byte_stb),
    .sync_code    (sync_code),
    .dreq_hold    (dreq_hold),
    .xfer_done    (xfer_done),
    .xfer_bytes   (xfer_bytes),
    .xfer_err_end (xfer_err_end),
    .chan_err     (chan_err),
    .mem_we       (mem_we)
);

// File: tb/sim_lpc_dma_sync_term.sv
module sim_lpc_dma_sync_term;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [1:0]  hdr_dir = 2'b00;
    logic        hdr_size16 = 1'b0;
    logic        hdr_chan16 = 1'b0;
    logic        byte_stb = 1'b0;
    logic [3:0]  sync_code = 4'b1111;
    logic [7:0]  byte_data = 8'h00;
    logic        dreq_hold, xfer_done, xfer_err_end, chan_err, mem_we;
    logic [1:0]  xfer_bytes;
    logic [15:0] mem_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lpc_dma_sync_term #(.DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dir(hdr_dir),
        .hdr_size16(hdr_size16), .hdr_chan16(hdr_chan16), .byte_stb(byte_stb),
        .sync_code(sync_code), .byte_data(byte_data), .dreq_hold(dreq_hold),
        .xfer_done(xfer_done), .xfer_bytes(xfer_bytes), .xfer_err_end(xfer_err_end),
        .chan_err(chan_err), .mem_we(mem_we), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic header(input logic [1:0] d, input logic s16, input logic c16);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_dir = d; hdr_size16 = s16; hdr_chan16 = c16;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic send(input logic [3:0] code, input logic [7:0] data);
        @(negedge clk);
        byte_stb = 1'b1; sync_code = code; byte_data = data;
        @(negedge clk);
        byte_stb = 1'b0; sync_code = 4'b1111;
    endtask

    task automatic t_reset;
        chk(dreq_hold == 1'b0, "R10 dreq", dreq_hold, 0);
        chk(xfer_done == 1'b0 && mem_we == 1'b0 && chan_err == 1'b0, "R10 pulses",
            {xfer_done, mem_we, chan_err}, 0);
    endtask

    task automatic t_idle_strobe;
        send(4'b0000, 8'h11);
        chk(xfer_done == 1'b0, "R2 idle strobe ignored", xfer_done, 0);
    endtask

    task automatic t_write16_full;
        header(2'b01, 1'b1, 1'b1);
        chk(dreq_hold == 1'b1, "R1 request raised", dreq_hold, 1);
        send(4'b1001, 8'hA5);
        chk(xfer_done == 1'b0, "R5 first byte continues", xfer_done, 0);
        send(4'b0000, 8'h3C);
        chk(xfer_done && xfer_bytes == 2'd2, "R6 two bytes", xfer_bytes, 2);
        chk(mem_we && mem_data == 16'h3CA5, "R8 packed data", mem_data, 16'h3CA5);
        chk(dreq_hold == 1'b0 && xfer_err_end == 1'b0, "R3 release", {dreq_hold, xfer_err_end}, 0);
        @(negedge clk);
        chk(xfer_done == 1'b0 && mem_we == 1'b0, "R6 single cycle pulse", {xfer_done, mem_we}, 0);
    endtask

    task automatic t_wait_states;
        header(2'b01, 1'b0, 1'b0);
        send(4'b0101, 8'hEE);
        send(4'b0110, 8'hEF);
        chk(xfer_done == 1'b0, "R2 wait code", xfer_done, 0);
        send(4'b0000, 8'h42);
        chk(xfer_done && xfer_bytes == 2'd1, "R2 count after waits", xfer_bytes, 1);
        chk(mem_we && mem_data == 16'h0042, "R8 8-bit upper zero", mem_data, 16'h0042);
    endtask

    task automatic t_read8_more;
        header(2'b00, 1'b0, 1'b0);
        send(4'b1001, 8'h77);
        chk(xfer_done && xfer_bytes == 2'd1, "R4 done on last byte", xfer_bytes, 1);
        chk(dreq_hold == 1'b1, "R4 request kept", dreq_hold, 1);
        chk(mem_we == 1'b0, "R9 read no write", mem_we, 0);
        send(4'b0000, 8'h01);
        chk(xfer_done == 1'b0 && dreq_hold == 1'b1, "R4 idle after done",
            {xfer_done, dreq_hold}, 1);
    endtask

    task automatic t_early_err_chan16(input logic [3:0] code);
        header(2'b01, 1'b1, 1'b1);
        send(code, 8'h5A);
        chk(xfer_done && xfer_bytes == 2'd1, "R3 cut short one byte", xfer_bytes, 1);
        chk(chan_err == 1'b1, "R7 chan16 error", chan_err, 1);
        chk(xfer_err_end == (code == 4'b1010), "R6 error-tag bit", xfer_err_end, code == 4'b1010);
        chk(mem_we && mem_data[7:0] == 8'h5A, "R8 low byte with pad", mem_data[7:0], 8'h5A);
        chk(dreq_hold == 1'b0, "R3 request dropped", dreq_hold, 0);
        send(4'b0000, 8'h99);
        chk(xfer_done == 1'b0, "R3 second byte not moved", xfer_done, 0);
    endtask

    task automatic t_early_chan8;
        header(2'b01, 1'b1, 1'b0);
        send(4'b0000, 8'h12);
        chk(xfer_done && chan_err == 1'b0, "R7 no error on 8-bit channel", chan_err, 0);
    endtask

    task automatic t_verify;
        header(2'b10, 1'b1, 1'b1);
        send(4'b1001, 8'h01);
        send(4'b1001, 8'h02);
        chk(xfer_done && mem_we == 1'b0, "R9 verify no write", mem_we, 0);
        chk(dreq_hold == 1'b1, "R4 verify request kept", dreq_hold, 1);
    endtask

    task automatic t_header_while_active;
        header(2'b01, 1'b1, 1'b0);
        send(4'b1001, 8'hC1);
        header(2'b00, 1'b0, 1'b0);
        chk(xfer_done == 1'b0, "R1 stray header no effect", xfer_done, 0);
        send(4'b1010, 8'hD2);
        chk(xfer_done && xfer_bytes == 2'd2 && mem_we, "R1 header ignored", xfer_bytes, 2);
        chk(mem_data == 16'hD2C1 && xfer_err_end, "R1 write kept", mem_data, 16'hD2C1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_strobe();
        t_write16_full();
        t_wait_states();
        t_read8_more();
        t_early_err_chan16(4'b1010);
        t_early_err_chan16(4'b0000);
        t_early_chan8();
        t_verify();
        t_header_while_active();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule